// File: doc/BRIEF.md
# Programmable Priority Channel Arbiter

This block chooses which of sixteen requesting channels a transfer engine serves next. Software gives each channel its own 4-bit level through a small byte-wide register port. In fixed mode, the pending channel with the numerically largest level wins. In rotating mode, the levels are ignored and service passes to the next pending channel after the one granted last. The winner is presented as a registered one-hot vector with a valid strobe, one clock after the requests were sampled.

Levels are only meaningful when they are all distinct. A set of comparators watches the stored levels and raises a configuration error whenever two channels share a value. While the error is up, nothing is granted. The sampled request vector can be read back through the register port, so software can see which channels are asking for service. Each channel register also keeps two preemption bits for a later transfer stage. They are stored and returned on reads, but the arbitration never looks at them.

Top module: `prio_arbiter`

## Requirements
- R1: After reset, the register at address n (0..15) reads n, the control register reads 0, `cfg_err` is 0 and `gnt`/`gnt_valid` are 0.
- R2: A write to address n (0..15) stores wdata bits 7, 6 and 3:0. A read of that address returns them in the same positions, with bits 5:4 always read as 0.
- R3: With control bit 0 clear, the grant registered at a clock edge selects, among the requests sampled at that edge, the channel with the numerically highest level (0 lowest, 15 highest).
- R4: `gnt` is one-hot or zero, and `gnt_valid` is high exactly when `gnt` is nonzero. No sampled request gives no grant.
- R5: While any two channels hold the same level, `cfg_err` is 1 and no grant is issued.
- R6: `cfg_err` returns to 0 in the cycle after a write that makes all sixteen levels distinct again, and grants resume.
- R7: With control bit 0 set, the grant goes to the first requesting channel found by searching upward from the most recently granted channel plus one, wrapping past 15. The levels are ignored. After reset, the last-granted channel is taken to be 15.
- R8: Address 17 reads the requests sampled at the most recent edge for channels 7:0, and address 18 reads them for channels 15:8. Bit i of each byte belongs to the lowest channel of that byte plus i.
- R9: Bits 7 and 6 of the channel registers have no effect on which channel is granted in either mode.
- R10: Address 16 is the control register. Bit 0 is the rotating-mode enable and reads back as written; its other bits read 0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| req_in | input | 16 | Per-channel service requests |
| gnt | output | 16 | One-hot grant |
| gnt_valid | output | 1 | High while a grant is presented |
| cfg_err | output | 1 | Duplicate-level configuration error |

## Verification
Fixed mode is driven with sparse and dense random request masks against random permutations of the levels. A dense mask shows whether the maximum search is correct, and single-bit masks show whether any pending channel can win at all. Rotating mode is driven with all channels requesting, which exposes the wrap and the pointer step, and with random masks, which show whether idle channels are skipped and levels ignored. Writes that create a duplicate level, and then repair it, separate error detection and grant blocking from normal selection. Random preemption bits set during both modes confirm that those bits are only carried along.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_CH     = 16;
  localparam int unsigned ARB_PRIO_W = 4;
  localparam int unsigned ARB_DATA_W = 8;
  // field positions inside a channel register
  localparam int unsigned PE_BIT = 7;
  localparam int unsigned PD_BIT = 6;
endpackage

// File: rtl/prio_regfile.sv
module prio_regfile
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CH = ARB_CH,
  parameter int unsigned PRIO_W = ARB_PRIO_W,
  parameter int unsigned ADDR_W = $clog2(NUM_CH + 3)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [ARB_DATA_W-1:0]         wdata,
  output logic [NUM_CH-1:0][PRIO_W-1:0] level,
  output logic [NUM_CH-1:0]             pe,
  output logic [NUM_CH-1:0]             pd,
  output logic                          rr_en
);
  localparam int unsigned CTRL_ADDR = NUM_CH;

  logic [NUM_CH-1:0][PRIO_W-1:0] lvl_q, lvl_d;
  logic [NUM_CH-1:0]             pe_q, pe_d, pd_q, pd_d;
  logic                          rr_q, rr_d;

  always_comb begin
    lvl_d = lvl_q;
    pe_d  = pe_q;
    pd_d  = pd_q;
    rr_d  = rr_q;
    if (we) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == ADDR_W'(i)) begin
          lvl_d[i] = wdata[PRIO_W-1:0];
          pe_d[i]  = wdata[PE_BIT];
          pd_d[i]  = wdata[PD_BIT];
        end
      end
      if (addr == ADDR_W'(CTRL_ADDR)) rr_d = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) lvl_q[i] <= PRIO_W'(i);
      pe_q <= '0;
      pd_q <= '0;
      rr_q <= 1'b0;
    end else if (we) begin
      lvl_q <= lvl_d;
      pe_q  <= pe_d;
      pd_q  <= pd_d;
      rr_q  <= rr_d;
    end
  end

  assign level = lvl_q;
  assign pe    = pe_q;
  assign pd    = pd_q;
  assign rr_en = rr_q;
endmodule

// File: rtl/dup_detect.sv
module dup_detect
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CH = ARB_CH,
  parameter int unsigned PRIO_W = ARB_PRIO_W
) (
  input  logic [NUM_CH-1:0][PRIO_W-1:0] level,
  output logic                          dup
);
  logic [NUM_CH-1:0] row_hit;

  // one comparator row per channel against every higher-indexed channel
  for (genvar i = 0; i < NUM_CH; i++) begin : g_row
    always_comb begin
      row_hit[i] = 1'b0;
      for (int j = i + 1; j < NUM_CH; j++) begin
        if (level[i] == level[j]) row_hit[i] = 1'b1;
      end
    end
  end

  assign dup = |row_hit;
endmodule

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CH = ARB_CH,
  parameter int unsigned PRIO_W = ARB_PRIO_W,
  parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]             req,
  input  logic [NUM_CH-1:0][PRIO_W-1:0] level,
  input  logic                          rr_en,
  input  logic [IDX_W-1:0]              last,
  output logic                          found,
  output logic [IDX_W-1:0]              win
);
  logic             fx_found, rr_found;
  logic [IDX_W-1:0] fx_win, rr_win;
  logic [PRIO_W-1:0] fx_best;

  // fixed mode: largest level among pending channels
  always_comb begin
    fx_found = 1'b0;
    fx_win   = '0;
    fx_best  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (!fx_found || level[i] > fx_best)) begin
        fx_found = 1'b1;
        fx_win   = IDX_W'(i);
        fx_best  = level[i];
      end
    end
  end

  // rotating mode: first pending channel after the last one served
  always_comb begin
    int idx;
    rr_found = 1'b0;
    rr_win   = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = (int'(last) + k) % NUM_CH;
      if (req[idx] && !rr_found) begin
        rr_found = 1'b1;
        rr_win   = IDX_W'(idx);
      end
    end
  end

  assign found = rr_en ? rr_found : fx_found;
  assign win   = rr_en ? rr_win   : fx_win;
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_CH = ARB_CH,
  parameter int unsigned PRIO_W = ARB_PRIO_W,
  parameter int unsigned ADDR_W = $clog2(NUM_CH + 3)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [ARB_DATA_W-1:0] reg_wdata,
  output logic [ARB_DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0]     req_in,
  output logic [NUM_CH-1:0]     gnt,
  output logic                  gnt_valid,
  output logic                  cfg_err
);
  localparam int unsigned IDX_W     = $clog2(NUM_CH);
  localparam int unsigned CTRL_ADDR = NUM_CH;
  localparam int unsigned STAT_ADDR = NUM_CH + 1;
  localparam int unsigned STAT_N    = (NUM_CH + ARB_DATA_W - 1) / ARB_DATA_W;

  logic [NUM_CH-1:0][PRIO_W-1:0] level;
  logic [NUM_CH-1:0]             pe, pd;
  logic                          rr_en, dup;
  logic                          sel_found;
  logic [IDX_W-1:0]              sel_win;

  logic [NUM_CH-1:0] gnt_q, gnt_d;
  logic              gv_q, gv_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic [NUM_CH-1:0] stat_q;

  prio_regfile #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .level(level), .pe(pe), .pd(pd), .rr_en(rr_en)
  );

  dup_detect #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dup (
    .level(level), .dup(dup)
  );

  arb_select #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .req(req_in), .level(level), .rr_en(rr_en), .last(last_q),
    .found(sel_found), .win(sel_win)
  );

  always_comb begin
    gnt_d  = '0;
    gv_d   = 1'b0;
    last_d = last_q;
    if (sel_found && !dup) begin
      gnt_d[sel_win] = 1'b1;
      gv_d           = 1'b1;
      last_d         = sel_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      gv_q   <= 1'b0;
      last_q <= IDX_W'(NUM_CH - 1);
      stat_q <= '0;
    end else begin
      gnt_q  <= gnt_d;
      gv_q   <= gv_d;
      last_q <= last_d;
      stat_q <= req_in;
    end
  end

  // register read mux
  always_comb begin
    logic [STAT_N*ARB_DATA_W-1:0] stat_ext;
    stat_ext  = '0;
    stat_ext[NUM_CH-1:0] = stat_q;
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ADDR_W'(i)) begin
        reg_rdata            = ARB_DATA_W'(level[i]);
        reg_rdata[PE_BIT]    = pe[i];
        reg_rdata[PD_BIT]    = pd[i];
      end
    end
    if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata = ARB_DATA_W'(rr_en);
    for (int b = 0; b < STAT_N; b++) begin
      if (reg_addr == ADDR_W'(STAT_ADDR + b))
        reg_rdata = stat_ext[b*ARB_DATA_W +: ARB_DATA_W];
    end
  end

  assign gnt       = gnt_q;
  assign gnt_valid = gv_q;
  assign cfg_err   = dup;
endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk #(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_in,
  input logic [NUM_CH-1:0] gnt,
  input logic              gnt_valid,
  input logic              cfg_err
);
  assert_gnt_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_valid_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid == (gnt != '0));

  assert_err_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !gnt_valid);

  assert_gnt_was_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ((gnt & $past(req_in)) != '0));
endmodule

bind prio_arbiter prio_arbiter_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .gnt(gnt),
  .gnt_valid(gnt_valid), .cfg_err(cfg_err)
);

// File: tb/prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module prio_arbiter_tb_top;
  logic        clk, rst_n, reg_we;
  logic [4:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [15:0] req_in, gnt;
  logic        gnt_valid, cfg_err;

  int checks = 0, failures = 0;
  logic [7:0] m_cfg [16];
  logic       m_rr;
  int         m_last;

  prio_arbiter dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_dup();
    for (int i = 0; i < 16; i++)
      for (int j = i + 1; j < 16; j++)
        if (m_cfg[i][3:0] == m_cfg[j][3:0]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_gnt(input logic [15:0] r);
    logic [15:0] g = '0;
    int best = -1, w = -1;
    if (m_dup()) return '0;
    if (m_rr) begin
      for (int k = 1; k <= 16; k++)
        if (w < 0 && r[(m_last + k) % 16]) w = (m_last + k) % 16;
    end else begin
      for (int i = 0; i < 16; i++)
        if (r[i] && int'(m_cfg[i][3:0]) > best) begin best = m_cfg[i][3:0]; w = i; end
    end
    if (w >= 0) g[w] = 1'b1;
    return g;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d; req_in = '0;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (a < 16) m_cfg[a] = d & 8'hCF;
    else if (a == 16) m_rr = d[0];
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_addr = 5'(a); #0.2; d = reg_rdata;
  endtask

  task automatic step(input logic [15:0] r);
    logic [15:0] e;
    logic [7:0]  lo, hi;
    @(negedge clk);
    req_in = r;
    e = exp_gnt(r);
    @(posedge clk); #1;
    if (m_rr) chk(gnt == e, "R7 rotating grant", gnt, e);
    else      chk(gnt == e, "R3 fixed grant", gnt, e);
    chk(gnt_valid == (e != 0), "R4 grant valid", gnt_valid, e != 0);
    chk(cfg_err == m_dup(), "R5 cfg_err", cfg_err, m_dup());
    rd(17, lo); rd(18, hi);
    chk({hi, lo} == r, "R8 status", {hi, lo}, r);
    for (int i = 0; i < 16; i++) if (e[i]) m_last = i;
  endtask

  task automatic shuffle_levels();
    int p [16];
    for (int i = 0; i < 16; i++) p[i] = i;
    for (int i = 15; i > 0; i--) begin
      int j = $urandom_range(i, 0);
      int t = p[i]; p[i] = p[j]; p[j] = t;
    end
    for (int i = 0; i < 16; i++) wr(i, {2'($urandom), 2'b00, 4'(p[i])});
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240607));
    reg_we = 0; reg_addr = 0; reg_wdata = 0; req_in = 0;
    rst_n = 0;
    for (int i = 0; i < 16; i++) m_cfg[i] = 8'(i);
    m_rr = 0; m_last = 15;
    #12 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk(gnt == 0 && !gnt_valid, "R1 no grant", gnt, 0);
    chk(!cfg_err, "R1 no error", cfg_err, 0);
    for (int i = 0; i < 16; i++) begin
      rd(i, d); chk(d == 8'(i), "R1 reset level", d, i);
    end
    rd(16, d); chk(d == 0, "R1 ctrl reset", d, 0);
    // R2 field storage, bits 5:4 read zero
    wr(3, 8'hF3); rd(3, d); chk(d == 8'hC3, "R2 readback", d, 8'hC3);
    wr(3, 8'h83); rd(3, d); chk(d == 8'h83, "R2 readback", d, 8'h83);
    // R10 control and unused address
    wr(16, 8'hFF); rd(16, d); chk(d == 8'h01, "R10 ctrl", d, 1);
    wr(16, 8'h00); rd(16, d); chk(d == 8'h00, "R10 ctrl", d, 0);
    rd(31, d); chk(d == 0, "R10 unused", d, 0);
    // R3 directed: highest level wins
    step(16'hFFFF); chk(gnt == 16'h8000, "R3 all request", gnt, 16'h8000);
    step(16'h0000); chk(!gnt_valid, "R4 idle", gnt_valid, 0);
    // R5 duplicate blocks grants
    wr(3, 8'h0F);
    chk(cfg_err, "R5 dup flagged", cfg_err, 1);
    step(16'hFFFF); chk(!gnt_valid, "R5 grant blocked", gnt_valid, 0);
    // R6 repair clears the error
    wr(3, 8'hC3);
    chk(!cfg_err, "R6 error cleared", cfg_err, 0);
    step(16'h0009); chk(gnt == 16'h0008, "R6 grants resume", gnt, 16'h0008);
    // R7 rotating with full mask
    wr(16, 8'h01);
    for (int n = 0; n < 20; n++) step(16'hFFFF);
    wr(16, 8'h00);
    // random phase, covers R9 through random top bits
    for (int n = 0; n < 3000; n++) begin
      int c = $urandom_range(99, 0);
      if (c < 2) shuffle_levels();
      else if (c < 4) wr(16, 8'($urandom_range(1, 0)));
      else if (c < 5) begin
        wr($urandom_range(15, 0), 8'($urandom));
        step(16'($urandom));
        shuffle_levels();
      end else begin
        logic [15:0] r;
        case ($urandom_range(2, 0))
          0: r = 16'($urandom) & 16'($urandom) & 16'($urandom);
          1: r = 16'(1) << $urandom_range(15, 0);
          default: r = 16'($urandom);
        endcase
        step(r);
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule